// File: doc/BRIEF.md
# NOR Flash Command Sequencer

The sequencer turns high-level requests from a host (sector erase, single-word program, device identify and device reset) into the sequence of word writes and word reads that a CFI-style NOR flash expects. It adds the two-write unlock preamble where a command needs it. It issues the command bytes at the correct offsets from the target sector. After an erase or a program it polls the device status word until the device reports ready, or until a programmable retry budget runs out. Each request ends with a single response that carries a result code.

Whenever an operation ends in a timeout, a device error or a failed identification, the sequencer writes the device reset command before it responds, so the flash is left in read mode. A multi-sector erase works through one sector at a time. It stops at the first sector that fails and reports that sector's base address. The flash side is a plain one-outstanding transaction port: a request is held until the device side acknowledges it, and read data comes back with the acknowledge.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, and at any time the sequencer is idle, `req_ready` is 1 and both `fl_req` and `rsp_valid` are 0.
- R2: An unlock pair is a write of 0x00AA at sector base + 0xAAA, followed by a write of 0x0055 at sector base + 0x554. The sector base is the request address with its low `SECT_LOG2` bits cleared. Identify uses base 0.
- R3: Erase (`req_op` = 0) runs the following steps for each sector: an unlock pair, 0x0080 at base + 0xAAA, a second unlock pair, 0x0030 at the sector base, then status polling.
- R4: Program (`req_op` = 1) runs an unlock pair, then 0x00A0 at base + 0xAAA, then `req_data` at the full `req_addr`, then status polling.
- R5: One status poll is a write of 0x0070 at base + 0xAAA followed by a read at the sector base. Bit 7 of the read word means ready. If a poll sees bit 7 clear and budget remains, another poll follows.
- R6: When a poll sees ready with bit 4 or bit 5 set, the result is I/O error (code 2). The sequencer writes 0x00F0 at address 0 and then responds.
- R7: The poll budget is `cfg_erase_budget` for erase and `cfg_prog_budget` for program, and a budget of 0 acts as 1. Once that many polls have all read not-ready, the result is timeout (code 1), after a write of 0x00F0 at address 0. A fully successful operation ends with code 0.
- R8: An erase whose `req_addr` or `req_len` has any of the low `SECT_LOG2` bits set gets code 3 on the cycle after acceptance, and no flash transaction is made. An aligned erase of length 0 gets code 0, also with no transaction.
- R9: Identify (`req_op` = 2) runs an unlock pair, 0x0090 at 0xAAA, a read at 0 and a read at 2. If the low nibble of the first word is not 0x1, or the low nibble of the second word is not 0xE, it writes 0x00F0 at 0 and responds with code 4. Otherwise it reads 0x4E, writes 0x00F0 at 0, and responds with code 0. In that case `rsp_id` = {second word, first word} and `rsp_size_log2` = the low byte of the 0x4E word.
- R10: A multi-sector erase handles sectors in ascending order. Each sector gets a fresh budget. The erase stops at the first failing sector, and `rsp_addr` is that sector's base. On success `rsp_addr` is the last sector's base.
- R11: Reset (`req_op` = 3) makes exactly one write of 0x00F0 at address 0 and responds with code 0.
- R12: A flash request keeps `fl_we`, `fl_addr` and `fl_wdata` stable until the cycle in which `fl_ack` is high.
- R13: After a not-ready status read, `fl_req` stays low for `cfg_poll_gap` + 1 cycles before the next poll command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 erase, 1 program, 2 identify, 3 reset |
| req_addr | input | ADDR_W | Byte address (erase start or program word) |
| req_len | input | ADDR_W | Erase length in bytes |
| req_data | input | 16 | Program data word |
| cfg_erase_budget | input | BUDGET_W | Status polls allowed per erased sector |
| cfg_prog_budget | input | BUDGET_W | Status polls allowed per program |
| cfg_poll_gap | input | GAP_W | Idle cycles between polls, minus one |
| fl_req | output | 1 | Flash transaction request |
| fl_we | output | 1 | 1 write, 0 read |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 16 | Write word |
| fl_ack | input | 1 | Transaction complete (read data valid) |
| fl_rdata | input | 16 | Read word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_code | output | 3 | 0 ok, 1 timeout, 2 I/O error, 3 rejected, 4 no device |
| rsp_addr | output | ADDR_W | Sector base of the last or failing sector |
| rsp_id | output | 32 | Identify words {second, first} |
| rsp_size_log2 | output | 8 | Log2 of device size from identify |

## Verification
The hardest situation to reach is a multi-sector erase in which one sector in the middle exhausts its budget. That case has to show that the earlier sector completed, that the failing sector got a fresh budget, that the reset write follows, and that the remaining sectors are never touched. The bench reaches it by scripting the flash replies as an ordered queue of expected transactions, with the status word that each read returns. A small erase budget combined with a queue of not-ready replies for the second sector forces the mid-run failure, and any transaction beyond the queue is flagged. The same queue carries a minimum spacing for polls that follow a not-ready read, which checks the inter-poll gap under nonzero acknowledge latency.

// File: rtl/nor_seq_pkg.sv
// Shared types and constants for the NOR flash command sequencer.
// Assumes 16-bit flash words and byte addressing on the flash port.
package nor_seq_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        OP_ERASE = 2'd0,
        OP_PROG  = 2'd1,
        OP_IDENT = 2'd2,
        OP_RESET = 2'd3
    } op_t;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_TIMEOUT = 3'd1,
        RES_IOERR   = 3'd2,
        RES_REJECT  = 3'd3,
        RES_NODEV   = 3'd4
    } res_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_UNLK_A, ST_UNLK_B, ST_CMD, ST_UNLK_C, ST_UNLK_D,
        ST_SECT, ST_DATA, ST_POLL_CMD, ST_POLL_RD, ST_GAP,
        ST_ID_LO, ST_ID_HI, ST_ID_SZ, ST_RST, ST_DONE
    } step_t;

    localparam logic [15:0] OFS_KEY1  = 16'h0AAA;
    localparam logic [15:0] OFS_KEY2  = 16'h0554;
    localparam logic [15:0] OFS_ID_HI = 16'h0002;
    localparam logic [15:0] OFS_SIZE  = 16'h004E;

    localparam logic [15:0] W_KEY1   = 16'h00AA;
    localparam logic [15:0] W_KEY2   = 16'h0055;
    localparam logic [15:0] W_ERASE  = 16'h0080;
    localparam logic [15:0] W_SECTOR = 16'h0030;
    localparam logic [15:0] W_PROG   = 16'h00A0;
    localparam logic [15:0] W_IDENT  = 16'h0090;
    localparam logic [15:0] W_STATUS = 16'h0070;
    localparam logic [15:0] W_RESET  = 16'h00F0;
endpackage

// File: rtl/nor_step_decode.sv
// Maps the current sequencer step to one flash transaction: request,
// direction, address and write word. Purely combinational.
// Assumes ADDR_W >= 16 and that base is sector aligned.
module nor_step_decode
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  step_t               step,
    input  op_t                 op,
    input  logic [ADDR_W-1:0]   base,
    input  logic [ADDR_W-1:0]   prog_addr,
    input  logic [WORD_W-1:0]   prog_data,
    output logic                bus_req,
    output logic                bus_we,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [WORD_W-1:0]   bus_wdata
);
    logic [ADDR_W-1:0] at_key1;
    logic [ADDR_W-1:0] at_key2;
    logic [WORD_W-1:0] cmd_word;

    // Offsets relative to the sector base
    assign at_key1 = base + ADDR_W'(OFS_KEY1);
    assign at_key2 = base + ADDR_W'(OFS_KEY2);

    // Command byte issued in the ST_CMD step, chosen by operation
    always_comb begin
        case (op)
            OP_ERASE: cmd_word = W_ERASE;
            OP_PROG:  cmd_word = W_PROG;
            OP_IDENT: cmd_word = W_IDENT;
            default:  cmd_word = W_RESET;
        endcase
    end

    // Step to transaction table
    always_comb begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = '0;
        bus_wdata = '0;
        case (step)
            ST_UNLK_A, ST_UNLK_C: begin bus_addr = at_key1; bus_wdata = W_KEY1; end
            ST_UNLK_B, ST_UNLK_D: begin bus_addr = at_key2; bus_wdata = W_KEY2; end
            ST_CMD:      begin bus_addr = at_key1; bus_wdata = cmd_word; end
            ST_SECT:     begin bus_addr = base; bus_wdata = W_SECTOR; end
            ST_DATA:     begin bus_addr = prog_addr; bus_wdata = prog_data; end
            ST_POLL_CMD: begin bus_addr = at_key1; bus_wdata = W_STATUS; end
            ST_POLL_RD:  begin bus_we = 1'b0; bus_addr = base; end
            ST_ID_LO:    begin bus_we = 1'b0; bus_addr = base; end
            ST_ID_HI:    begin bus_we = 1'b0; bus_addr = base + ADDR_W'(OFS_ID_HI); end
            ST_ID_SZ:    begin bus_we = 1'b0; bus_addr = base + ADDR_W'(OFS_SIZE); end
            ST_RST:      begin bus_addr = '0; bus_wdata = W_RESET; end
            default:     begin bus_req = 1'b0; bus_we = 1'b0; end
        endcase
    end
endmodule

// File: rtl/nor_retry_ctr.sv
// Counts the status polls left for the current sector or program.
// A budget of 0 behaves like 1: `last` is high when at most one poll remains.
module nor_retry_ctr #(
    parameter int BUDGET_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                sel_erase,
    input  logic [BUDGET_W-1:0] budget_erase,
    input  logic [BUDGET_W-1:0] budget_prog,
    input  logic                dec,
    output logic                last
);
    logic [BUDGET_W-1:0] left_q;

    // Load a fresh budget or consume one poll
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= sel_erase ? budget_erase : budget_prog;
        end else if (dec && left_q > BUDGET_W'(1)) begin
            left_q <= left_q - BUDGET_W'(1);
        end
    end

    assign last = (left_q <= BUDGET_W'(1));
endmodule

// File: rtl/nor_gap_timer.sv
// Down-counter that spaces consecutive status polls.
// Loaded on `start`; `expired` is high once it has counted to zero.
module nor_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [GAP_W-1:0] gap_len,
    output logic             expired
);
    logic [GAP_W-1:0] cnt_q;

    // Reload on start, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= gap_len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - GAP_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nor_cmd_seq.sv
// NOR flash command sequencer. It expands host requests into unlock and
// command writes, polls the status word within a retry budget, and resets
// the device after any failure. Assumes one outstanding flash transaction,
// with fl_ack completing it and fl_rdata valid alongside fl_ack on reads.
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W    = 26,
    parameter int SECT_LOG2 = 18,
    parameter int BUDGET_W  = 20,
    parameter int GAP_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [ADDR_W-1:0]   req_len,
    input  logic [15:0]         req_data,
    input  logic [BUDGET_W-1:0] cfg_erase_budget,
    input  logic [BUDGET_W-1:0] cfg_prog_budget,
    input  logic [GAP_W-1:0]    cfg_poll_gap,
    output logic                fl_req,
    output logic                fl_we,
    output logic [ADDR_W-1:0]   fl_addr,
    output logic [15:0]         fl_wdata,
    input  logic                fl_ack,
    input  logic [15:0]         fl_rdata,
    output logic                rsp_valid,
    output logic [2:0]          rsp_code,
    output logic [ADDR_W-1:0]   rsp_addr,
    output logic [31:0]         rsp_id,
    output logic [7:0]          rsp_size_log2
);
    localparam int CNT_W = ADDR_W - SECT_LOG2;
    localparam logic [ADDR_W-1:0] BASE_MASK = {ADDR_W{1'b1}} << SECT_LOG2;
    localparam logic [ADDR_W-1:0] SECT_STEP = ADDR_W'(1) << SECT_LOG2;

    step_t              state_q;
    op_t                op_q;
    res_t               res_q;
    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  paddr_q;
    logic [WORD_W-1:0]  pdata_q;
    logic [CNT_W-1:0]   left_q;
    logic [WORD_W-1:0]  id_lo_q;
    logic [WORD_W-1:0]  id_hi_q;
    logic [7:0]         size_q;

    logic              bus_req;
    logic              xfer;
    logic              accept;
    logic              misalign;
    logic [CNT_W-1:0]  sect_cnt;
    logic              st_ready;
    logic              st_err;
    logic              id_ok;
    logic              more;
    logic              rc_load;
    logic              rc_sel;
    logic              rc_dec;
    logic              rc_last;
    logic              gap_start;
    logic              gap_done;

    // Request decode and status interpretation
    assign accept   = req_valid && (state_q == ST_IDLE);
    assign xfer     = bus_req && fl_ack;
    assign misalign = (|req_addr[SECT_LOG2-1:0]) || (|req_len[SECT_LOG2-1:0]);
    assign sect_cnt = req_len[ADDR_W-1:SECT_LOG2];
    assign st_ready = fl_rdata[7];
    assign st_err   = fl_rdata[5] || fl_rdata[4];
    assign id_ok    = (id_lo_q[3:0] == 4'h1) && (fl_rdata[3:0] == 4'hE);
    assign more     = (left_q > CNT_W'(1));

    // Retry and gap control pulses
    assign rc_sel    = accept ? (op_t'(req_op) == OP_ERASE) : (op_q == OP_ERASE);
    assign rc_load   = (accept && (op_t'(req_op) == OP_ERASE || op_t'(req_op) == OP_PROG)) ||
                       (state_q == ST_POLL_RD && xfer && st_ready && !st_err &&
                        op_q == OP_ERASE && more);
    assign rc_dec    = (state_q == ST_POLL_RD) && xfer && !st_ready;
    assign gap_start = rc_dec && !rc_last;

    nor_step_decode #(.ADDR_W(ADDR_W)) u_decode (
        .step      (state_q),
        .op        (op_q),
        .base      (base_q),
        .prog_addr (paddr_q),
        .prog_data (pdata_q),
        .bus_req   (bus_req),
        .bus_we    (fl_we),
        .bus_addr  (fl_addr),
        .bus_wdata (fl_wdata)
    );

    nor_retry_ctr #(.BUDGET_W(BUDGET_W)) u_retry (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (rc_load),
        .sel_erase    (rc_sel),
        .budget_erase (cfg_erase_budget),
        .budget_prog  (cfg_prog_budget),
        .dec          (rc_dec),
        .last         (rc_last)
    );

    nor_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (gap_start),
        .gap_len (cfg_poll_gap),
        .expired (gap_done)
    );

    // Sequencer state and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_RESET;
            res_q   <= RES_OK;
            base_q  <= '0;
            paddr_q <= '0;
            pdata_q <= '0;
            left_q  <= '0;
            id_lo_q <= '0;
            id_hi_q <= '0;
            size_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    op_q  <= op_t'(req_op);
                    res_q <= RES_OK;
                    case (op_t'(req_op))
                        OP_ERASE: begin
                            base_q <= req_addr;
                            left_q <= sect_cnt;
                            if (misalign) begin
                                res_q   <= RES_REJECT;
                                state_q <= ST_DONE;
                            end else if (sect_cnt == '0) begin
                                state_q <= ST_DONE;
                            end else begin
                                state_q <= ST_UNLK_A;
                            end
                        end
                        OP_PROG: begin
                            base_q  <= req_addr & BASE_MASK;
                            paddr_q <= req_addr;
                            pdata_q <= req_data;
                            state_q <= ST_UNLK_A;
                        end
                        OP_IDENT: begin
                            base_q  <= '0;
                            state_q <= ST_UNLK_A;
                        end
                        default: begin
                            base_q  <= '0;
                            state_q <= ST_RST;
                        end
                    endcase
                end
                ST_UNLK_A: if (xfer) state_q <= ST_UNLK_B;
                ST_UNLK_B: if (xfer) state_q <= ST_CMD;
                ST_CMD: if (xfer) begin
                    case (op_q)
                        OP_ERASE: state_q <= ST_UNLK_C;
                        OP_PROG:  state_q <= ST_DATA;
                        default:  state_q <= ST_ID_LO;
                    endcase
                end
                ST_UNLK_C:   if (xfer) state_q <= ST_UNLK_D;
                ST_UNLK_D:   if (xfer) state_q <= ST_SECT;
                ST_SECT:     if (xfer) state_q <= ST_POLL_CMD;
                ST_DATA:     if (xfer) state_q <= ST_POLL_CMD;
                ST_POLL_CMD: if (xfer) state_q <= ST_POLL_RD;
                ST_POLL_RD: if (xfer) begin
                    if (st_ready) begin
                        if (st_err) begin
                            res_q   <= RES_IOERR;
                            state_q <= ST_RST;
                        end else if (op_q == OP_ERASE && more) begin
                            left_q  <= left_q - CNT_W'(1);
                            base_q  <= base_q + SECT_STEP;
                            state_q <= ST_UNLK_A;
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end else if (rc_last) begin
                        res_q   <= RES_TIMEOUT;
                        state_q <= ST_RST;
                    end else begin
                        state_q <= ST_GAP;
                    end
                end
                ST_GAP: if (gap_done) state_q <= ST_POLL_CMD;
                ST_ID_LO: if (xfer) begin
                    id_lo_q <= fl_rdata;
                    state_q <= ST_ID_HI;
                end
                ST_ID_HI: if (xfer) begin
                    id_hi_q <= fl_rdata;
                    if (id_ok) begin
                        state_q <= ST_ID_SZ;
                    end else begin
                        res_q   <= RES_NODEV;
                        state_q <= ST_RST;
                    end
                end
                ST_ID_SZ: if (xfer) begin
                    size_q  <= fl_rdata[7:0];
                    state_q <= ST_RST;
                end
                ST_RST:  if (xfer) state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Host-facing outputs
    assign req_ready     = (state_q == ST_IDLE);
    assign fl_req        = bus_req;
    assign rsp_valid     = (state_q == ST_DONE);
    assign rsp_code      = res_q;
    assign rsp_addr      = base_q;
    assign rsp_id        = {id_hi_q, id_lo_q};
    assign rsp_size_log2 = size_q;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
// Protocol checker for nor_cmd_seq, attached by bind. It observes ports only.
module nor_cmd_seq_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              fl_req,
    input logic              fl_we,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [15:0]       fl_wdata,
    input logic              fl_ack,
    input logic              rsp_valid,
    input logic [2:0]        rsp_code
);
    // R1: an idle sequencer neither drives the flash nor responds
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!fl_req && !rsp_valid));

    // R12: a pending request keeps its fields until acknowledged
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_we) && $stable(fl_addr) && $stable(fl_wdata)));

    // R6 / R7 / R9: every failure response directly follows the device reset write
    a_r7_fail_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_code == 3'd1 || rsp_code == 3'd2 || rsp_code == 3'd4)) |->
        $past(fl_req && fl_ack && fl_we && fl_addr == '0 && fl_wdata == 16'h00F0));

    // R8: a rejection arrives on the cycle after acceptance
    a_r8_reject_at_once: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd3) |-> $past(req_valid && req_ready));

    // R1: the response is a single pulse followed by idle
    a_r1_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .fl_req    (fl_req),
    .fl_we     (fl_we),
    .fl_addr   (fl_addr),
    .fl_wdata  (fl_wdata),
    .fl_ack    (fl_ack),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code)
);

// File: tb/nor_cmd_seq_tb.sv
// Testbench: a queue of expected flash transactions, each carrying the
// reply for reads and a minimum spacing, is checked on every clock.
module nor_cmd_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 26;
    localparam int BUDGET_W   = 20;
    localparam int GAP_W      = 16;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        bit          we;
        int unsigned addr;
        bit [15:0]   data;
        int          gap;
        string       tag;
    } txn_t;

    logic clk, rst_n;
    logic req_valid, req_ready;
    logic [1:0] req_op;
    logic [ADDR_W-1:0] req_addr, req_len;
    logic [15:0] req_data;
    logic [BUDGET_W-1:0] cfg_erase_budget, cfg_prog_budget;
    logic [GAP_W-1:0] cfg_poll_gap;
    logic fl_req, fl_we, fl_ack;
    logic [ADDR_W-1:0] fl_addr;
    logic [15:0] fl_wdata, fl_rdata;
    logic rsp_valid;
    logic [2:0] rsp_code;
    logic [ADDR_W-1:0] rsp_addr;
    logic [31:0] rsp_id;
    logic [7:0] rsp_size_log2;

    txn_t  exp_q[$];
    int    n_chk = 0, n_fail = 0;
    int    cyc = 0, last_ack = 0, wcnt = 0, lat = 0;
    string cur_tag = "R1";

    nor_cmd_seq #(.ADDR_W(ADDR_W), .SECT_LOG2(18), .BUDGET_W(BUDGET_W), .GAP_W(GAP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
        .cfg_erase_budget(cfg_erase_budget), .cfg_prog_budget(cfg_prog_budget),
        .cfg_poll_gap(cfg_poll_gap), .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_ack(fl_ack), .fl_rdata(fl_rdata), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_addr(rsp_addr), .rsp_id(rsp_id), .rsp_size_log2(rsp_size_log2)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic pw(input int unsigned a, input bit [15:0] d, input int g);
        txn_t t;
        t.we = 1'b1; t.addr = a; t.data = d; t.gap = g; t.tag = cur_tag;
        exp_q.push_back(t);
    endtask

    task automatic pr(input int unsigned a, input bit [15:0] d);
        txn_t t;
        t.we = 1'b0; t.addr = a; t.data = d; t.gap = 0; t.tag = cur_tag;
        exp_q.push_back(t);
    endtask

    task automatic unlock(input int unsigned b);
        pw(b + 'hAAA, 16'h00AA, 0);
        pw(b + 'h554, 16'h0055, 0);
    endtask

    task automatic poll(input int unsigned b, input bit [15:0] st, input int g);
        pw(b + 'hAAA, 16'h0070, g);
        pr(b, st);
    endtask

    task automatic erase_head(input int unsigned b);
        unlock(b);
        pw(b + 'hAAA, 16'h0080, 0);
        unlock(b);
        pw(b, 16'h0030, 0);
    endtask

    task automatic dev_reset();
        pw(0, 16'h00F0, 0);
    endtask

    // Flash model: acknowledges after `lat` cycles, checks each transaction
    initial begin
        fl_ack = 1'b0;
        fl_rdata = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                chk(1'b0, cur_tag, "watchdog expired", cyc, WATCHDOG);
                finish_run();
            end
            if (fl_ack) begin
                fl_ack = 1'b0;
                wcnt = 0;
            end else if (fl_req) begin
                if (wcnt < lat) begin
                    wcnt++;
                end else begin
                    fl_ack = 1'b1;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, cur_tag, "unexpected flash transaction at", fl_addr, 0);
                        fl_rdata = '0;
                    end else begin
                        txn_t t;
                        t = exp_q.pop_front();
                        chk(fl_we == t.we, t.tag, "direction", fl_we, t.we);
                        chk(fl_addr == t.addr[ADDR_W-1:0], t.tag, "address", fl_addr, t.addr);
                        if (t.we) chk(fl_wdata == t.data, t.tag, "write word", fl_wdata, t.data);
                        else fl_rdata = t.data;
                        if (t.gap > 0) chk(cyc - last_ack >= t.gap, "R13", "poll spacing", cyc - last_ack, t.gap);
                    end
                    last_ack = cyc;
                end
            end
        end
    end

    task automatic run(input logic [1:0] op, input int unsigned addr, input int unsigned len,
                       input logic [15:0] data, input logic [2:0] ecode, input int unsigned eaddr);
        bit got;
        got = 1'b0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr[ADDR_W-1:0];
        req_len = len[ADDR_W-1:0]; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (rsp_valid) begin got = 1'b1; break; end
            @(negedge clk);
        end
        chk(got, cur_tag, "response seen", got, 1);
        chk(rsp_code == ecode, cur_tag, "result code", rsp_code, ecode);
        chk(rsp_addr == eaddr[ADDR_W-1:0], cur_tag, "response address", rsp_addr, eaddr);
        chk(exp_q.size() == 0, cur_tag, "transactions left unissued", exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_len = '0; req_data = '0;
        cfg_erase_budget = 20'd50; cfg_prog_budget = 20'd20; cfg_poll_gap = 16'd3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_tag = "R1";
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(fl_req == 1'b0, "R1", "no flash request after reset", fl_req, 0);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);

        // R11: reset request
        cur_tag = "R11"; lat = 0;
        dev_reset();
        run(2'd3, 0, 0, 16'h0, 3'd0, 0);

        // R2 R4 R5 R13: program with two not-ready polls
        cur_tag = "R4"; lat = 2;
        unlock('h100000);
        pw('h100000 + 'hAAA, 16'h00A0, 0);
        pw('h123456, 16'hBEEF, 0);
        poll('h100000, 16'h0000, 0);
        poll('h100000, 16'h0040, 5);
        poll('h100000, 16'h0080, 5);
        run(2'd1, 'h123456, 0, 16'hBEEF, 3'd0, 'h100000);

        // R6: program reports a program error
        cur_tag = "R6"; lat = 1;
        unlock('h0);
        pw('hAAA, 16'h00A0, 0);
        pw('h0010, 16'h1234, 0);
        poll('h0, 16'h0090, 0);
        dev_reset();
        run(2'd1, 'h0010, 0, 16'h1234, 3'd2, 'h0);

        // R3: single-sector erase
        cur_tag = "R3"; lat = 0;
        erase_head('h40000);
        poll('h40000, 16'h0080, 0);
        run(2'd0, 'h40000, 'h40000, 16'h0, 3'd0, 'h40000);

        // R6: erase reports an erase error
        cur_tag = "R6";
        erase_head('h40000);
        poll('h40000, 16'h00A0, 0);
        dev_reset();
        run(2'd0, 'h40000, 'h40000, 16'h0, 3'd2, 'h40000);

        // R7: program budget of 3 runs out
        cur_tag = "R7"; cfg_prog_budget = 20'd3; cfg_poll_gap = 16'd0; lat = 1;
        unlock('h200000);
        pw('h200000 + 'hAAA, 16'h00A0, 0);
        pw('h200002, 16'h5A5A, 0);
        poll('h200000, 16'h0000, 0);
        poll('h200000, 16'h0000, 2);
        poll('h200000, 16'h0000, 2);
        dev_reset();
        run(2'd1, 'h200002, 0, 16'h5A5A, 3'd1, 'h200000);

        // R7: a budget of zero allows exactly one poll
        cfg_prog_budget = 20'd0;
        unlock('h0);
        pw('hAAA, 16'h00A0, 0);
        pw('h4, 16'h0001, 0);
        poll('h0, 16'h0000, 0);
        dev_reset();
        run(2'd1, 'h4, 0, 16'h0001, 3'd1, 'h0);

        // R8: misaligned address, misaligned length, zero length
        cur_tag = "R8"; cfg_prog_budget = 20'd20; cfg_poll_gap = 16'd3;
        run(2'd0, 'h40010, 'h40000, 16'h0, 3'd3, 'h40010);
        run(2'd0, 'h80000, 'h40100, 16'h0, 3'd3, 'h80000);
        run(2'd0, 'h80000, 'h0, 16'h0, 3'd0, 'h80000);

        // R10: three-sector erase, second sector times out, third untouched
        cur_tag = "R10"; cfg_erase_budget = 20'd2; lat = 2;
        erase_head('h80000);
        poll('h80000, 16'h0080, 0);
        erase_head('hC0000);
        poll('hC0000, 16'h0000, 0);
        poll('hC0000, 16'h0000, 5);
        dev_reset();
        run(2'd0, 'h80000, 'hC0000, 16'h0, 3'd1, 'hC0000);

        // R10: two-sector erase succeeds, fresh budget for each sector
        erase_head('h0);
        poll('h0, 16'h0000, 0);
        poll('h0, 16'h0080, 5);
        erase_head('h40000);
        poll('h40000, 16'h0000, 0);
        poll('h40000, 16'h0080, 5);
        run(2'd0, 'h0, 'h80000, 16'h0, 3'd0, 'h40000);

        // R9: identify, accepted device
        cur_tag = "R9"; lat = 0;
        unlock('h0);
        pw('hAAA, 16'h0090, 0);
        pr('h0, 16'h2201);
        pr('h2, 16'h227E);
        pr('h4E, 16'h001A);
        dev_reset();
        run(2'd2, 0, 0, 16'h0, 3'd0, 0);
        chk(rsp_id == 32'h227E2201, "R9", "identify words", rsp_id, 32'h227E2201);
        chk(rsp_size_log2 == 8'h1A, "R9", "size exponent", rsp_size_log2, 8'h1A);

        // R9: identify, rejected device (no size read)
        unlock('h0);
        pw('hAAA, 16'h0090, 0);
        pr('h0, 16'h0003);
        pr('h2, 16'h007E);
        dev_reset();
        run(2'd2, 0, 0, 16'h0, 3'd4, 0);

        cur_tag = "R1";
        chk(req_ready == 1'b1 && fl_req == 1'b0, "R1", "idle at end", {req_ready, fl_req}, 2'b10);
        finish_run();
    end
endmodule